// File: doc/BRIEF.md
# Host Interrupt Line Controller

This block drives a single active-low interrupt wire toward a host processor. It collects one-cycle event pulses from eight internal sources into a pending-status register. It exposes a small register port that the host uses to read and clear the pending bitmap and to set or clear a global mask. The wire is held low from reset until the core reports that its configuration is finished. After that it rests high, and a falling edge on it signals that work is waiting.

The host services an interrupt in four steps. It sees the wire fall and sets the mask, which releases the wire. It reads the status register, which returns every pending source and empties the register in the same cycle. It handles the sources and then clears the mask. If events arrived while the host was busy, the wire falls again. Events are never dropped, including an event that lands in the same cycle as the clearing read.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset, `irq_n` is 0, the pending status is empty, the mask is clear and `host_rdata` is 0.
- R2: Until `cfg_done` has been seen high at a clock edge, `irq_n` stays 0 whatever the events or the mask.
- R3: Once `cfg_done` is seen, the block is armed permanently. With nothing pending and the mask clear, `irq_n` is 1 from the next edge on.
- R4: When armed and unmasked, a pulse on `evt_in` bit i sets pending bit i at that edge, and `irq_n` falls to 0 one edge later.
- R5: Writing `host_wbit`=1 to address 1 sets the mask. From the following edge `irq_n` is 1, and pending bits are kept.
- R6: A read of address 0 puts the pending bitmap (bit i = source i, upper bits 0) on `host_rdata` at the read edge and clears the pending bits.
- R7: An event arriving in the same cycle as a status read is absent from that read's data and is pending for the next read.
- R8: Writing `host_wbit`=0 to address 1 clears the mask. If anything is pending, `irq_n` falls again one edge later.
- R9: A write to address 0 has no effect on the pending bits. A read of address 1 returns the mask in bit 0 and leaves the pending bits untouched.
- R10: Pending bits accumulate: events from separate cycles are OR-ed together until a status read clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Core configuration finished; arms the line (sticky) |
| evt_in | input | NUM_SRC | One-cycle event pulses, one per source |
| host_rd | input | 1 | Register read strobe |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register address: 0 status, 1 mask |
| host_wbit | input | 1 | Write data (mask value) |
| host_rdata | output | DATA_W | Registered read data |
| irq_n | output | 1 | Active-low interrupt line to the host |

## Verification
The bench sweeps every one of the 256 event bitmaps through the full assert, mask, read and unmask handshake. A design that lost a source, or failed to clear on read, would return a wrong bitmap or leave the wire low after unmasking. Separate cases cover an event colliding with the clearing read and events pending before arming. A design that cleared the colliding event would return 0 on the second read. A design that let the wire idle high before configuration would show 1 during that phase. A status write that was not ignored would empty the register, and a mask read that cleared status would lose bits.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int unsigned REG_STATUS = 0;
  localparam int unsigned REG_MASK   = 1;
endpackage

// File: rtl/irq_pend_store.sv
module irq_pend_store #(
  parameter int NUM_SRC = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               rd_clr_i,
  output logic [NUM_SRC-1:0] status_o
);
  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)
        status_o[g] <= 1'b0;
      else if (rd_clr_i)
        status_o[g] <= evt_i[g];
      else
        status_o[g] <= status_o[g] | evt_i[g];
    end
  end

  // R6: a clearing read with no new events leaves nothing pending
  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_clr_i && evt_i == '0) |=> (status_o == '0));
  // R7: an event colliding with the read survives it
  p_collide_kept_r7: assert property (@(posedge clk) disable iff (rst)
    rd_clr_i |=> (status_o == $past(evt_i)));
  // R10: no pending bit is dropped without a read
  p_no_loss_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_clr_i |=> ((status_o & $past(status_o)) == $past(status_o)));
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg (
  input  logic clk,
  input  logic rst,
  input  logic cfg_done_i,
  input  logic mask_we_i,
  input  logic mask_wbit_i,
  output logic mask_o,
  output logic armed_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o  <= 1'b0;
      armed_o <= 1'b0;
    end else begin
      if (cfg_done_i) armed_o <= 1'b1;
      if (mask_we_i)  mask_o  <= mask_wbit_i;
    end
  end

  // R3: arming is permanent
  p_arm_sticky_r3: assert property (@(posedge clk) disable iff (rst)
    armed_o |=> armed_o);
  // R5: the mask holds without a write
  p_mask_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !mask_we_i |=> $stable(mask_o));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv (
  input  logic clk,
  input  logic rst,
  input  logic armed_i,
  input  logic mask_i,
  input  logic pending_i,
  output logic irq_n_o
);
  logic assert_req;

  always_comb assert_req = pending_i & ~mask_i;

  always_ff @(posedge clk) begin
    if (rst)
      irq_n_o <= 1'b0;
    else
      irq_n_o <= armed_i & ~assert_req;
  end

  // R2: line parked low until armed
  p_low_until_armed_r2: assert property (@(posedge clk) disable iff (rst)
    !armed_i |=> !irq_n_o);
  // R5: a masked, armed block keeps the line released
  p_masked_high_r5: assert property (@(posedge clk) disable iff (rst)
    (armed_i && mask_i) |=> irq_n_o);
  // R4: pending and unmasked pulls the line low
  p_pend_low_r4: assert property (@(posedge clk) disable iff (rst)
    (armed_i && !mask_i && pending_i) |=> !irq_n_o);
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl #(
  parameter int NUM_SRC = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_done,
  input  logic [NUM_SRC-1:0] evt_in,
  input  logic               host_rd,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic               host_wbit,
  output logic [DATA_W-1:0]  host_rdata,
  output logic               irq_n
);
  import host_irq_pkg::*;

  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(REG_STATUS);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(REG_MASK);

  logic [NUM_SRC-1:0] status;
  logic               mask_q;
  logic               armed_q;
  logic               rd_status;
  logic               wr_mask;
  logic [DATA_W-1:0]  rd_word;

  always_comb begin
    rd_status = host_rd && (host_addr == A_STATUS);
    wr_mask   = host_wr && (host_addr == A_MASK);
  end

  irq_pend_store #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (evt_in),
    .rd_clr_i (rd_status),
    .status_o (status)
  );

  irq_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .cfg_done_i  (cfg_done),
    .mask_we_i   (wr_mask),
    .mask_wbit_i (host_wbit),
    .mask_o      (mask_q),
    .armed_o     (armed_q)
  );

  irq_line_drv u_line (
    .clk       (clk),
    .rst       (rst),
    .armed_i   (armed_q),
    .mask_i    (mask_q),
    .pending_i (|status),
    .irq_n_o   (irq_n)
  );

  always_comb begin
    rd_word = '0;
    if (host_addr == A_STATUS)
      rd_word[NUM_SRC-1:0] = status;
    else if (host_addr == A_MASK)
      rd_word[0] = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_rd)
      host_rdata <= rd_word;
  end

  // R1: reset leaves the line low and read data empty
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (!irq_n && host_rdata == '0));
  // R9: a mask-address read never clears pending bits
  p_mask_read_keeps_r9: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == A_MASK) |=> ((status & $past(status)) == $past(status)));
endmodule

// File: tb/test_host_irq_ctrl.sv
module test_host_irq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NSRC = 8;

  logic            clk = 1'b0;
  logic            rst;
  logic            cfg_done;
  logic [NSRC-1:0] evt_in;
  logic            host_rd;
  logic            host_wr;
  logic [0:0]      host_addr;
  logic            host_wbit;
  logic [7:0]      host_rdata;
  logic            irq_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_irq_ctrl #(.NUM_SRC(NSRC), .DATA_W(8), .ADDR_W(1)) i_host_irq_ctrl (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .evt_in(evt_in),
    .host_rd(host_rd), .host_wr(host_wr), .host_addr(host_addr),
    .host_wbit(host_wbit), .host_rdata(host_rdata), .irq_n(irq_n)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [NSRC-1:0] p);
    evt_in = p; step(); evt_in = '0;
  endtask

  task automatic wr_mask(input logic v);
    host_wr = 1'b1; host_addr = 1'b1; host_wbit = v; step(); host_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic a);
    host_rd = 1'b1; host_addr = a; step(); host_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_done = 1'b0; evt_in = '0; host_rd = 1'b0;
    host_wr = 1'b0; host_addr = 1'b0; host_wbit = 1'b0;
    step(); step();
    rst = 1'b0;
    // R1 reset state
    check(irq_n == 1'b0, "R1 irq_n", irq_n, 0);
    check(host_rdata == 8'h00, "R1 rdata", host_rdata, 0);

    // R2: events before arming keep the line low
    pulse(8'h05); step(); step();
    check(irq_n == 1'b0, "R2 pre-arm line", irq_n, 0);
    wr_mask(1'b1); step();
    check(irq_n == 1'b0, "R2 pre-arm masked line", irq_n, 0);
    wr_mask(1'b0);
    rd_reg(1'b0);
    check(host_rdata == 8'h05, "R6 pre-arm status", host_rdata, 8'h05);

    // R3: arming
    cfg_done = 1'b1; step(); cfg_done = 1'b0; step();
    check(irq_n == 1'b1, "R3 armed idle", irq_n, 1);
    step(); step(); step();
    check(irq_n == 1'b1, "R3 sticky arm", irq_n, 1);

    // Sweep all bitmaps through the handshake
    for (int p = 0; p < 256; p++) begin
      pulse(p[7:0]); step();
      check(irq_n == (p == 0), "R4 line falls", irq_n, (p == 0));
      wr_mask(1'b1); step();
      check(irq_n == 1'b1, "R5 mask releases", irq_n, 1);
      rd_reg(1'b0);
      check(host_rdata == p[7:0], "R6 status read", host_rdata, p);
      wr_mask(1'b0); step();
      check(irq_n == 1'b1, "R6 cleared then unmasked", irq_n, 1);
    end

    // R7 and R8: collision with the read, then unmask re-asserts
    for (int s = 0; s < NSRC; s++) begin
      logic [7:0] a, b;
      a = 8'(1 << s);
      b = 8'(1 << ((s + 3) % NSRC));
      pulse(a); step();
      wr_mask(1'b1);
      host_rd = 1'b1; host_addr = 1'b0; evt_in = b; step();
      host_rd = 1'b0; evt_in = '0;
      check(host_rdata == a, "R7 read excludes colliding event", host_rdata, a);
      wr_mask(1'b0); step();
      check(irq_n == 1'b0, "R8 unmask with pending", irq_n, 0);
      rd_reg(1'b0);
      check(host_rdata == b, "R7 colliding event kept", host_rdata, b);
      step();
      check(irq_n == 1'b1, "R8 line released after clear", irq_n, 1);
    end

    // R9: status write ignored, mask read non-destructive
    wr_mask(1'b1);
    pulse(8'h3C);
    host_wr = 1'b1; host_addr = 1'b0; host_wbit = 1'b1; step(); host_wr = 1'b0;
    rd_reg(1'b1);
    check(host_rdata == 8'h01, "R9 mask readback", host_rdata, 1);
    rd_reg(1'b1);
    check(host_rdata == 8'h01, "R9 second mask read", host_rdata, 1);
    rd_reg(1'b0);
    check(host_rdata == 8'h3C, "R9 status intact", host_rdata, 8'h3C);

    // R10: accumulation across cycles
    pulse(8'h81); step(); pulse(8'h12); pulse(8'h01);
    rd_reg(1'b0);
    check(host_rdata == 8'h93, "R10 accumulate", host_rdata, 8'h93);
    wr_mask(1'b0);
    rd_reg(1'b1);
    check(host_rdata == 8'h00, "R8 mask cleared readback", host_rdata, 0);
    step();
    check(irq_n == 1'b1, "R8 idle after service", irq_n, 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule